// File: doc/BRIEF.md
# Parity-Protected Byte Memory With Fault Injection

This block is a small byte memory in which every location holds nine bits: eight data bits and one parity bit. The parity bit is generated when a byte is written and checked every time that byte is read. In normal use the generator writes odd parity, so every correctly stored word has an odd number of ones across all nine bits.

A software-controlled input, `inj_even`, switches only the write-side generator to even parity. A byte written while it is high is stored with a wrong parity bit. The checker always tests for odd parity, so any later read of that byte is reported as bad. This gives software a way to prove that the detector works without disturbing the rest of the system.

A detected error sets a sticky flag at bit 5 of a status byte. The address of the first failing read is captured at the same moment. Both stay until software pulses `clr_err`.

Top module: `parity_ram`

## Requirements
- R1: After reset, `status` is 0, `err_addr` is 0 and `rd_valid` is 0.
- R2: A read issued with `rd_en` in one cycle returns the stored byte on `rd_data` with `rd_valid` high after the next rising edge. `rd_valid` is high for exactly that one cycle. A byte written with `inj_even` low reads back unchanged, and `status` bit 5 stays low.
- R3: A byte written with `inj_even` high and read back with `inj_even` low sets `status` bit 5 after the read's edge.
- R4: The checker always tests for odd parity, so a bad word read while `inj_even` is still high is also flagged.
- R5: `status` bit 5 is sticky: once set, it stays high through later good reads until `clr_err` is pulsed.
- R6: `err_addr` takes the address of the read that first sets the flag. It ignores later failing reads while the flag stays set.
- R7: A `clr_err` pulse with no failing read in the same cycle clears `status` bit 5 and `err_addr` to 0 at the next edge.
- R8: When `clr_err` and a failing read fall in the same cycle, the read wins. The flag stays set and `err_addr` takes that read's address.
- R9: `status` bit 4 shows whether the most recent read failed its parity check, and is updated on every read. `status` bit 0 mirrors `inj_even`. Bits 7, 6, 3, 2 and 1 are always 0.
- R10: A write and a read to the same address in the same cycle return the old content. The new content is visible to the next read.
- R11: Rewriting a poisoned location with `inj_even` low restores good parity, and reading it then raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Shared location address |
| wdata | input | 8 | Byte to store |
| inj_even | input | 1 | 1 = generate even parity on writes (injects errors) |
| clr_err | input | 1 | One-cycle pulse that clears the sticky flag and captured address |
| rd_data | output | 8 | Byte from the last read |
| rd_valid | output | 1 | High for one cycle after a read |
| status | output | 8 | Bit 5 sticky error, bit 4 last-read error, bit 0 injection mode, others 0 |
| err_addr | output | AW | Address of the first failing read since the last clear |

## Verification
The bench checks three ways a faulty design could go wrong:
- **Checker mode.** A checker that followed the injection control, instead of always testing odd parity, would accept a poisoned word read while injection is still on.
- **Flag and capture rules.** A flag that was not sticky would drop after a good read. An address capture without first-fail priority would drift to the latest failing address. A clear that took priority over a same-cycle failure would lose a real error.
- **Memory ordering.** A memory that forwarded write data would return the new byte on a simultaneous read and write to one address. A generator that ignored the mode would never raise the flag at all.

// File: rtl/parity_ram.sv
module parity_ram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          inj_even,
  input  logic          clr_err,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic [7:0]    status,
  output logic [AW-1:0] err_addr
);
  localparam int DEPTH = 1 << AW;

  logic [8:0] mem [DEPTH];
  logic       wpar;
  logic [8:0] rword;
  logic       rbad;
  logic       sticky;
  logic       last_bad;

  assign wpar  = inj_even ? ^wdata : ~^wdata;
  assign rword = mem[addr];
  assign rbad  = ~^rword;

  always_ff @(posedge clk)
    if (wr_en) mem[addr] <= {wpar, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      last_bad <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data  <= rword[7:0];
        last_bad <= rbad;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky   <= 1'b0;
      err_addr <= '0;
    end else if (rd_en && rbad && (!sticky || clr_err)) begin
      sticky   <= 1'b1;
      err_addr <= addr;
    end else if (clr_err) begin
      sticky   <= 1'b0;
      err_addr <= '0;
    end
  end

  assign status = {2'b00, sticky, last_bad, 3'b000, inj_even};
endmodule

module parity_ram_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          clr_err,
  input logic          rd_valid,
  input logic [7:0]    status,
  input logic [AW-1:0] err_addr
);
  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !clr_err) |=> status[5]);
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !clr_err) |=> $stable(err_addr));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !rd_en) |=> (!status[5] && err_addr == '0));
  p_flag_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && status[4]) |-> status[5]);
  p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:6] == 2'b00 && status[3:1] == 3'b000));
endmodule

bind parity_ram parity_ram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .clr_err(clr_err),
  .rd_valid(rd_valid), .status(status), .err_addr(err_addr)
);

// File: tb/tb_parity_ram.sv
module tb_parity_ram;
  localparam int AW = 6;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, inj_even = 0, clr_err = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rd_data, status;
  logic rd_valid;
  logic [AW-1:0] err_addr;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  parity_ram #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .inj_even(inj_even), .clr_err(clr_err),
    .rd_data(rd_data), .rd_valid(rd_valid), .status(status), .err_addr(err_addr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_read(logic [AW-1:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr_err = 1;
    @(negedge clk); clr_err = 0;
  endtask

  task automatic t_reset();
    check("R1 status", status, 0);
    check("R1 err_addr", err_addr, 0);
    check("R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_clean();
    logic [7:0] pat [3] = '{8'hA5, 8'h00, 8'hFF};
    for (int i = 0; i < 3; i++) do_write(AW'(3 + i), pat[i]);
    for (int i = 0; i < 3; i++) begin
      do_read(AW'(3 + i));
      check("R2 data", rd_data, pat[i]);
      check("R2 valid", rd_valid, 1);
      check("R2 no flag", status[5], 0);
      check("R9 last read ok", status[4], 0);
      @(negedge clk);
      check("R2 valid one cycle", rd_valid, 0);
    end
  endtask

  task automatic t_inject_in_mode();
    @(negedge clk); inj_even = 1;
    #1 check("R9 mode bit", status[0], 1);
    do_write(10, 8'h3C);
    do_read(10);
    check("R4 flag with injection still on", status[5], 1);
    check("R9 last read bad", status[4], 1);
    check("R6 captured addr", err_addr, 10);
    check("R9 zero bits", {status[7:6], status[3:1]}, 0);
    @(negedge clk); inj_even = 0;
    #1 check("R9 mode bit off", status[0], 0);
  endtask

  task automatic t_sticky();
    do_read(3);
    check("R5 sticky after good read", status[5], 1);
    check("R9 last read now ok", status[4], 0);
    @(negedge clk); inj_even = 1;
    do_write(20, 8'h81);
    @(negedge clk); inj_even = 0;
    do_read(20);
    check("R6 first address kept", err_addr, 10);
    check("R5 still set", status[5], 1);
  endtask

  task automatic t_clear();
    pulse_clear();
    check("R7 flag cleared", status[5], 0);
    check("R7 addr cleared", err_addr, 0);
    do_read(4);
    check("R7 stays clear after good read", status[5], 0);
    do_read(20);
    check("R3 flag after odd-mode read", status[5], 1);
    check("R3 data still returned", rd_data, 8'h81);
    check("R6 addr of failing read", err_addr, 20);
  endtask

  task automatic t_clear_race();
    @(negedge clk); clr_err = 1; rd_en = 1; addr = 10;
    @(negedge clk); clr_err = 0; rd_en = 0;
    check("R8 read wins over clear", status[5], 1);
    check("R8 new address", err_addr, 10);
    pulse_clear();
  endtask

  task automatic t_rewrite();
    do_write(10, 8'h3C);
    do_read(10);
    check("R11 repaired word clean", status[5], 0);
    check("R11 data", rd_data, 8'h3C);
  endtask

  task automatic t_same_cycle();
    do_write(7, 8'h11);
    @(negedge clk); wr_en = 1; rd_en = 1; addr = 7; wdata = 8'h22;
    @(negedge clk); wr_en = 0; rd_en = 0;
    check("R10 old data on collision", rd_data, 8'h11);
    do_read(7);
    check("R10 new data next read", rd_data, 8'h22);
    check("R10 no flag", status[5], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_inject_in_mode();
    t_sticky();
    t_clear();
    t_clear_race();
    t_rewrite();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule